// File: doc/BRIEF.md
# Accumulator CPU Core

This block is a very small 8-bit processor built around two registers: an accumulator and an index-like register called X. It runs from a private 64-byte memory. The program occupies addresses 0 to 31, and data occupies addresses 32 to 63. There are no flags. Conditional branches look directly at whether the accumulator and X currently hold the same value.

Every instruction passes through three states: fetch, decode and execute. The memory reads synchronously, and each state makes at most one memory access. The only output is a registered data port with a one-cycle valid strobe. An idle flag rises once the program parks itself on a jump to its own address. A testbench places the program and the data directly into the internal memory before it releases reset.

An instruction byte carries a 3-bit major opcode in bits 7:5 and a 5-bit field in bits 4:0. Memory operands always land in the data half. Jump and branch targets always land in the program half.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, the core clears the program counter, the accumulator, X, the output valid strobe and the idle flag. After reset, execution starts at address 0.
- R2: Each instruction takes exactly three clock cycles. Two output instructions placed back to back therefore raise the valid strobe exactly 3 cycles apart.
- R3: Major opcode 000 loads the accumulator from address {1, field}. Major opcode 010 loads X from the same kind of address.
- R4: Major opcode 001 writes the accumulator to address {1, field}. It never modifies the program half.
- R5: Major opcode 011 jumps unconditionally to program address {0, field}.
- R6: Major opcode 101 branches to {0, field} when the accumulator equals X. Major opcode 100 branches when they differ. In both cases the comparison uses the register values present at execute.
- R7: Under major opcode 111, minor code 00000 clears the accumulator. Minor code 00001 increments it, and the increment wraps from 0xFF to 0x00.
- R8: Minor code 00010 under major opcode 111 presents the accumulator on the data output and raises the valid strobe for exactly one clock cycle.
- R9: Major opcode 110 and every undefined minor code under 111 change no register and no memory location. They only advance the program counter.
- R10: The 5-bit program counter wraps from 31 to 0 when it increments.
- R11: The idle flag rises when a jump (opcode 011) targets its own address. The flag then stays high until reset. A jump to any other address leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| out_data | output | 8 | Value captured by the last output instruction |
| out_valid | output | 1 | One-cycle strobe marking a new out_data value |
| idle | output | 1 | Program has parked on a self-jump |

## Verification
The bench builds the core with its default parameters: 8-bit data and a 6-bit address space. With these values the 5-bit program counter can reach its wrap point with a short detour to address 31. The 8-bit accumulator can also be driven to 0xFF with a single preloaded byte, so the increment wrap is easy to reach. A vector table runs one fixed load, increment and compare program over several pairs of accumulator and X values, covering both branch outcomes and the wrap case. Directed programs then cover reset values, strobe spacing, store placement, no-operation codes and program counter wrap.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2
   } state_e;

   typedef enum logic [2:0] {
      OP_LDA = 3'b000,
      OP_STA = 3'b001,
      OP_LDX = 3'b010,
      OP_JMP = 3'b011,
      OP_BNE = 3'b100,
      OP_BEQ = 3'b101,
      OP_RSV = 3'b110,
      OP_EXT = 3'b111
   } major_e;

   localparam int MAJOR_W = 3;
   localparam int MN_CLR  = 0;
   localparam int MN_INC  = 1;
   localparam int MN_OUT  = 2;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[addr] <= wdata;
      rdata <= mem_q[addr];
   end
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_acc,
   input  logic              ld_x,
   input  logic              clr_acc,
   input  logic              inc_acc,
   input  logic              emit,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] acc,
   output logic              acc_eq_x,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid
);
   logic [DATA_W-1:0] acc_q, x_q, out_q;
   logic              valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         x_q     <= '0;
         out_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         if (clr_acc)      acc_q <= '0;
         else if (inc_acc) acc_q <= acc_q + 1'b1;
         else if (ld_acc)  acc_q <= din;
         if (ld_x) x_q <= din;
         valid_q <= emit;
         if (emit) out_q <= acc_q;
      end
   end

   assign acc       = acc_q;
   assign acc_eq_x  = (acc_q == x_q);
   assign out_data  = out_q;
   assign out_valid = valid_q;
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] rdata,
   input  logic              acc_eq_x,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              ld_acc,
   output logic              ld_x,
   output logic              clr_acc,
   output logic              inc_acc,
   output logic              emit,
   output state_e            state,
   output logic              idle
);
   localparam int FIELD_W = ADDR_W - 1;

   state_e             state_q;
   logic [FIELD_W-1:0] pc_q;
   logic [DATA_W-1:0]  ir_q;
   logic               idle_q;

   major_e             major;
   logic [FIELD_W-1:0] field;
   logic               in_exec, is_ext, take_jump, self_jump;

   assign major   = major_e'(ir_q[DATA_W-1 -: MAJOR_W]);
   assign field   = ir_q[FIELD_W-1:0];
   assign in_exec = (state_q == ST_EXEC);
   assign is_ext  = in_exec && (major == OP_EXT);

   assign ld_acc  = in_exec && (major == OP_LDA);
   assign ld_x    = in_exec && (major == OP_LDX);
   assign mem_we  = in_exec && (major == OP_STA);
   assign clr_acc = is_ext && (field == FIELD_W'(MN_CLR));
   assign inc_acc = is_ext && (field == FIELD_W'(MN_INC));
   assign emit    = is_ext && (field == FIELD_W'(MN_OUT));

   always_comb begin
      take_jump = 1'b0;
      case (major)
         OP_JMP:  take_jump = 1'b1;
         OP_BNE:  take_jump = !acc_eq_x;
         OP_BEQ:  take_jump = acc_eq_x;
         default: take_jump = 1'b0;
      endcase
   end

   assign self_jump = in_exec && (major == OP_JMP) && (field == pc_q);

   always_comb begin
      case (state_q)
         ST_FETCH:  mem_addr = {1'b0, pc_q};
         ST_DECODE: mem_addr = {1'b1, rdata[FIELD_W-1:0]};
         default:   mem_addr = {1'b1, field};
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
         ir_q    <= '0;
         idle_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_FETCH:  state_q <= ST_DECODE;
            ST_DECODE: begin
               ir_q    <= rdata;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               pc_q    <= take_jump ? field : pc_q + 1'b1;
               state_q <= ST_FETCH;
               if (self_jump) idle_q <= 1'b1;
            end
            default:   state_q <= ST_FETCH;
         endcase
      end
   end

   assign state = state_q;
   assign idle  = idle_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              idle
);
   localparam int FIELD_W = ADDR_W - 1;

   generate
      if (DATA_W != MAJOR_W + FIELD_W) begin : g_bad_fmt
         $error("acc_cpu: DATA_W must equal 3 + ADDR_W - 1");
      end
      if (FIELD_W < 2) begin : g_bad_addr
         $error("acc_cpu: ADDR_W must leave room for minor codes");
      end
   endgenerate

   logic [ADDR_W-1:0] mem_addr;
   logic              mem_we;
   logic [DATA_W-1:0] mem_rdata, acc;
   logic              ld_acc, ld_x, clr_acc, inc_acc, emit, acc_eq_x;
   state_e            fsm_state;

   acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (acc),
      .rdata (mem_rdata)
   );

   acc_cpu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .rdata    (mem_rdata),
      .acc_eq_x (acc_eq_x),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .ld_acc   (ld_acc),
      .ld_x     (ld_x),
      .clr_acc  (clr_acc),
      .inc_acc  (inc_acc),
      .emit     (emit),
      .state    (fsm_state),
      .idle     (idle)
   );

   acc_cpu_dpath #(.DATA_W(DATA_W)) u_dpath (
      .clk       (clk),
      .rst       (rst),
      .ld_acc    (ld_acc),
      .ld_x      (ld_x),
      .clr_acc   (clr_acc),
      .inc_acc   (inc_acc),
      .emit      (emit),
      .din       (mem_rdata),
      .acc       (acc),
      .acc_eq_x  (acc_eq_x),
      .out_data  (out_data),
      .out_valid (out_valid)
   );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              out_valid,
   input logic              idle,
   input state_e            state,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && !idle && state == ST_FETCH)); // R1

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid); // R8

   AST_VALID_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(state == ST_EXEC)); // R2

   AST_STATE_ORDER: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (state == ST_DECODE)); // R2

   AST_STORE_DATA_HALF: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_addr[ADDR_W-1] && state == ST_EXEC)); // R4

   AST_FETCH_PROG_HALF: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |-> !mem_addr[ADDR_W-1]); // R10

   AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (rst)
      idle |=> idle); // R11
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .idle      (idle),
   .state     (fsm_state),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] out_data;
   logic       out_valid, idle;

   int checks = 0, errors = 0, cyc = 0;
   logic [7:0] obuf [16];
   int         ocyc [16];
   logic       oidle[16];
   int         ocnt = 0;

   always #5 clk = ~clk;

   acc_cpu uut (.clk(clk), .rst(rst), .out_data(out_data),
                .out_valid(out_valid), .idle(idle));

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (!rst && out_valid && ocnt < 16) begin
         obuf[ocnt] = out_data;
         ocyc[ocnt] = cyc;
         oidle[ocnt] = idle;
         ocnt = ocnt + 1;
      end
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL R2 watchdog: actual %0d cycles, expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ins(input int op, input int f);
      return {op[2:0], f[4:0]};
   endfunction

   localparam int LDA = 0, STA = 1, LDX = 2, JMP = 3, BNE = 4, BEQ = 5,
                  RSV = 6, EXT = 7;

   task automatic poke(input int a, input logic [7:0] v);
      uut.u_mem.mem_q[a] = v;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 64; i++) uut.u_mem.mem_q[i] = 8'h00;
   endtask

   task automatic start();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ocnt = 0;
      rst = 1'b0;
   endtask

   task automatic run_to_idle();
      for (int i = 0; i < 400 && !idle; i++) @(negedge clk);
      chk(idle == 1'b1, "R11", "idle reached", idle, 1);
   endtask

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] x;
      logic [7:0] first;
      logic       taken;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'h05, 8'h06, 8'h06, 1'b1},
      '{8'h05, 8'h05, 8'h06, 1'b0},
      '{8'hFF, 8'h00, 8'h00, 1'b1},
      '{8'h10, 8'h20, 8'h11, 1'b0},
      '{8'hFF, 8'hFF, 8'h00, 1'b0},
      '{8'h7F, 8'h80, 8'h80, 1'b1}
   };

   initial begin
      // Reset state: R1
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
      chk(idle == 1'b0, "R1", "idle in reset", idle, 0);

      // Vector table: R3 R6 R7 R8
      foreach (VECS[v]) begin
         @(negedge clk);
         rst = 1'b1;
         clear_mem();
         poke(0, ins(LDA, 0));
         poke(1, ins(LDX, 1));
         poke(2, ins(EXT, 1));
         poke(3, ins(EXT, 2));
         poke(4, ins(BEQ, 7));
         poke(5, ins(EXT, 0));
         poke(6, ins(EXT, 2));
         poke(7, ins(EXT, 2));
         poke(8, ins(JMP, 8));
         poke(32, VECS[v].a);
         poke(33, VECS[v].x);
         start();
         run_to_idle();
         chk(ocnt == (VECS[v].taken ? 2 : 3), "R6", "output count", ocnt,
             VECS[v].taken ? 2 : 3);
         chk(obuf[0] == VECS[v].first, "R7", "incremented load", obuf[0],
             VECS[v].first);
         chk(obuf[1] == (VECS[v].taken ? VECS[v].first : 8'h00), "R3",
             "second output", obuf[1], VECS[v].taken ? VECS[v].first : 0);
         chk(oidle[0] == 1'b0, "R11", "idle low while running", oidle[0], 0);
      end

      // Strobe timing and reset values: R1 R2 R8 R6
      @(negedge clk);
      rst = 1'b1;
      clear_mem();
      poke(0, ins(EXT, 2));
      poke(1, ins(EXT, 2));
      poke(2, ins(BEQ, 5));
      poke(3, ins(EXT, 1));
      poke(4, ins(EXT, 2));
      poke(5, ins(EXT, 2));
      poke(6, ins(JMP, 6));
      start();
      run_to_idle();
      chk(ocnt == 3, "R6", "reset acc equals reset x", ocnt, 3);
      chk(obuf[0] == 8'h00, "R1", "acc after reset", obuf[0], 0);
      chk(ocyc[1] - ocyc[0] == 3, "R2", "strobe spacing", ocyc[1] - ocyc[0], 3);
      chk(ocyc[0] == ocyc[1] - 3 && obuf[2] == 8'h00, "R8", "third output",
          obuf[2], 0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(idle == 1'b1, "R11", "idle sticky", idle, 1);
         chk(out_valid == 1'b0, "R8", "no strobe when parked", out_valid, 0);
      end

      // Store lands in data half: R4 R3
      @(negedge clk);
      rst = 1'b1;
      clear_mem();
      poke(0, ins(LDA, 3));
      poke(1, ins(STA, 4));
      poke(2, ins(EXT, 0));
      poke(3, ins(LDA, 4));
      poke(4, ins(EXT, 2));
      poke(5, ins(JMP, 5));
      poke(35, 8'h5A);
      start();
      run_to_idle();
      chk(ocnt == 1, "R4", "program half untouched", ocnt, 1);
      chk(obuf[0] == 8'h5A, "R4", "stored value read back", obuf[0], 8'h5A);

      // No-operation codes: R9
      @(negedge clk);
      rst = 1'b1;
      clear_mem();
      poke(0, ins(EXT, 1));
      poke(1, ins(RSV, 0));
      poke(2, ins(EXT, 7));
      poke(3, ins(EXT, 31));
      poke(4, ins(EXT, 2));
      poke(5, ins(JMP, 5));
      start();
      run_to_idle();
      chk(ocnt == 1, "R9", "nop output count", ocnt, 1);
      chk(obuf[0] == 8'h01, "R9", "acc unchanged by nops", obuf[0], 1);

      // Program counter wrap and jump: R10 R5
      @(negedge clk);
      rst = 1'b1;
      clear_mem();
      poke(0, ins(LDX, 1));
      poke(1, ins(EXT, 1));
      poke(2, ins(EXT, 2));
      poke(3, ins(BEQ, 5));
      poke(4, ins(JMP, 31));
      poke(5, ins(JMP, 5));
      poke(31, ins(EXT, 1));
      poke(33, 8'h03);
      start();
      run_to_idle();
      chk(ocnt == 2, "R10", "wrap output count", ocnt, 2);
      chk(obuf[0] == 8'h01, "R5", "before jump", obuf[0], 1);
      chk(obuf[1] == 8'h03, "R10", "after wrap", obuf[1], 3);
      chk(oidle[1] == 1'b0, "R11", "jump elsewhere keeps idle low", oidle[1], 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule